// File: doc/BRIEF.md
# Critical Section Call Queue

This block collects critical-section call requests from a group of small cores and feeds them to one large core that runs the sections on their behalf. Each request names a lock address, the entry program counter, the caller's stack pointer and the caller's core number. The queue keeps up to eight such requests. It hands a request to one of the large core's two thread contexts only when the request's lock is not held by a section that is already running. When the large core reports that the section under a lock has finished, the queue returns a done response to the core that made that request.

Dispatch is offered directly from the stored state, and the large core takes the request on the same clock edge. Among the requests that could run, the one that arrived first wins. A 2-bit saturating counter tracks false serialization, meaning cycles in which a request with a free lock is stuck only because both contexts are busy with other locks. A stuck request raises the counter once per cycle. A request that reaches a context without ever being stuck that way lowers it.

Top module: `cs_call_queue`

## Requirements
- R1: `req_ready` is high while fewer than 8 entries are stored and low when all 8 are in use. A request offered while `req_ready` is low is not taken. It is taken at the first edge at which `req_ready` is high.
- R2: An entry whose lock is free is offered in the cycle after the edge that stored it. While a context is free, `disp_valid` is high and `disp_lock`, `disp_pc` and `disp_sp` carry that entry's stored fields. The offer is taken at that same edge.
- R3: No two running entries share a lock address. A request for a lock that is running stays stored and is offered in the cycle after the edge that accepts that lock's completion.
- R4: At most two entries run at once. `disp_ctx` names the lowest-numbered free context: 0 before 1.
- R5: When several entries could run, the one stored earliest is offered, whatever table slot it sits in.
- R6: A completion whose `done_lock` matches a running entry removes that entry and frees its context. In the next cycle `resp_valid` pulses high for one cycle, with `resp_core` equal to the stored core number.
- R7: A completion that matches no running entry changes no entry. In the next cycle `err_pulse` pulses high for one cycle and `resp_valid` stays low.
- R8: `fs_count` rises by one, saturating at 3, after each edge at which some stored entry with a free lock waits while both contexts are busy. It falls by one, not below 0, when an entry that never waited that way is dispatched.
- R9: Reset empties the table, frees both contexts and sets `fs_count` to 0, leaving `req_ready` high and `disp_valid`, `resp_valid` and `err_pulse` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Call request present |
| req_ready | output | 1 | Table can accept a request |
| req_lock | input | AW | Lock address of the request |
| req_pc | input | AW | Entry program counter of the section |
| req_sp | input | AW | Caller stack pointer |
| req_core | input | IW | Requesting core number |
| disp_valid | output | 1 | An entry is handed to a context at this edge |
| disp_ctx | output | 1 | Context receiving the entry |
| disp_lock | output | AW | Lock address of the dispatched entry |
| disp_pc | output | AW | Program counter of the dispatched entry |
| disp_sp | output | AW | Stack pointer of the dispatched entry |
| done_valid | input | 1 | Large core reports a finished section |
| done_lock | input | AW | Lock address of the finished section |
| resp_valid | output | 1 | Done response to a small core |
| resp_core | output | IW | Core the done response is routed to |
| err_pulse | output | 1 | Completion matched no running entry |
| fs_count | output | FW | False-serialization saturating counter |

## Verification
Dispatch outputs depend only on registered state. They are therefore due in the first cycle after the edge that stored the entry or freed its lock or context. `resp_valid`, `resp_core` and `err_pulse` are registered, so they appear one cycle after the completion edge. `fs_count` reflects the edges before the current cycle. The bench changes inputs on the falling edge and samples outputs on that same falling edge before driving new inputs. Each expected value thus refers to the state left by the previous rising edge, and the vector table is laid out with that one-cycle offset.

// File: rtl/cs_call_queue.sv
module cs_call_queue #(
  parameter int DEPTH = 8,
  parameter int AW    = 32,
  parameter int IW    = 3,
  parameter int FW    = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_lock,
  input  logic [AW-1:0] req_pc,
  input  logic [AW-1:0] req_sp,
  input  logic [IW-1:0] req_core,
  output logic          disp_valid,
  output logic          disp_ctx,
  output logic [AW-1:0] disp_lock,
  output logic [AW-1:0] disp_pc,
  output logic [AW-1:0] disp_sp,
  input  logic          done_valid,
  input  logic [AW-1:0] done_lock,
  output logic          resp_valid,
  output logic [IW-1:0] resp_core,
  output logic          err_pulse,
  output logic [FW-1:0] fs_count
);
  localparam int XW = $clog2(DEPTH);
  localparam logic [FW-1:0] FS_MAX = '1;

  logic [DEPTH-1:0] valid, exec, waited;
  logic [DEPTH-1:0] ectx;
  logic [DEPTH-1:0] older [DEPTH];
  logic [AW-1:0]    lock_q [DEPTH];
  logic [AW-1:0]    pc_q   [DEPTH];
  logic [AW-1:0]    sp_q   [DEPTH];
  logic [IW-1:0]    core_q [DEPTH];
  logic [1:0]       ctx_busy;

  logic [DEPTH-1:0] held, elig, blk, hit;
  logic [XW-1:0]    sel, slot, hidx;
  logic             hit_any, free_any;

  assign free_any  = ~&ctx_busy;
  assign disp_ctx  = ctx_busy[0];
  assign req_ready = ~&valid;
  assign disp_valid = |elig;
  assign disp_lock = lock_q[sel];
  assign disp_pc   = pc_q[sel];
  assign disp_sp   = sp_q[sel];
  assign hit_any   = |hit;

  always_comb begin
    held = '0;
    for (int i = 0; i < DEPTH; i++)
      for (int j = 0; j < DEPTH; j++)
        if (exec[j] && lock_q[j] == lock_q[i]) held[i] = 1'b1;
    for (int i = 0; i < DEPTH; i++) begin
      elig[i] = valid[i] && !exec[i] && !held[i] && free_any;
      blk[i]  = valid[i] && !exec[i] && !held[i] && !free_any;
      hit[i]  = done_valid && exec[i] && lock_q[i] == done_lock;
    end
    sel = '0;
    for (int i = 0; i < DEPTH; i++)
      if (elig[i] && !(|(older[i] & elig))) sel = XW'(i);
    slot = '0;
    for (int i = DEPTH - 1; i >= 0; i--)
      if (!valid[i]) slot = XW'(i);
    hidx = '0;
    for (int i = 0; i < DEPTH; i++)
      if (hit[i]) hidx = XW'(i);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid <= '0; exec <= '0; waited <= '0; ectx <= '0;
      ctx_busy <= '0; fs_count <= '0;
      resp_valid <= 1'b0; resp_core <= '0; err_pulse <= 1'b0;
      for (int i = 0; i < DEPTH; i++) begin
        older[i] <= '0; lock_q[i] <= '0; pc_q[i] <= '0;
        sp_q[i] <= '0; core_q[i] <= '0;
      end
    end else begin
      waited <= waited | blk;
      if (hit_any) begin
        valid[hidx] <= 1'b0;
        exec[hidx]  <= 1'b0;
        ctx_busy[ectx[hidx]] <= 1'b0;
      end
      if (disp_valid) begin
        exec[sel] <= 1'b1;
        ectx[sel] <= disp_ctx;
        ctx_busy[disp_ctx] <= 1'b1;
      end
      if (req_valid && req_ready) begin
        for (int k = 0; k < DEPTH; k++) older[k][slot] <= 1'b0;
        older[slot]  <= valid & ~hit;
        valid[slot]  <= 1'b1;
        exec[slot]   <= 1'b0;
        waited[slot] <= 1'b0;
        lock_q[slot] <= req_lock;
        pc_q[slot]   <= req_pc;
        sp_q[slot]   <= req_sp;
        core_q[slot] <= req_core;
      end
      if (|blk) begin
        if (fs_count != FS_MAX) fs_count <= fs_count + 1'b1;
      end else if (disp_valid && !waited[sel] && fs_count != '0)
        fs_count <= fs_count - 1'b1;
      resp_valid <= hit_any;
      resp_core  <= core_q[hidx];
      err_pulse  <= done_valid && !hit_any;
    end
  end

  logic dup_exec;
  always_comb begin
    dup_exec = 1'b0;
    for (int i = 0; i < DEPTH; i++)
      for (int j = i + 1; j < DEPTH; j++)
        if (exec[i] && exec[j] && lock_q[i] == lock_q[j]) dup_exec = 1'b1;
  end

  // R3
  unique_lock_chk: assert property (@(posedge clk) disable iff (!rst_n) !dup_exec);

  // R4
  ctx_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(exec) == $countones(ctx_busy));

  // R1
  full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_ready && !done_valid) |=> !req_ready);

  // R6
  resp_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> ($past(done_valid) && !err_pulse));

  // R7
  err_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_pulse |-> $past(done_valid));

  // R2
  disp_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    disp_valid |-> !(&ctx_busy));
endmodule

// File: tb/cs_call_queue_tb.sv
module cs_call_queue_tb;
  localparam int AW = 32;
  localparam int IW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, done_valid = 1'b0;
  logic [AW-1:0] req_lock = '0, req_pc, req_sp, done_lock = '0;
  logic [IW-1:0] req_core = '0;
  logic req_ready, disp_valid, disp_ctx, resp_valid, err_pulse;
  logic [AW-1:0] disp_lock, disp_pc, disp_sp;
  logic [IW-1:0] resp_core;
  logic [1:0] fs_count;
  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  assign req_pc = req_lock + 32'h100;
  assign req_sp = req_lock + 32'h200;

  cs_call_queue u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_lock(req_lock), .req_pc(req_pc), .req_sp(req_sp), .req_core(req_core),
    .disp_valid(disp_valid), .disp_ctx(disp_ctx), .disp_lock(disp_lock),
    .disp_pc(disp_pc), .disp_sp(disp_sp), .done_valid(done_valid),
    .done_lock(done_lock), .resp_valid(resp_valid), .resp_core(resp_core),
    .err_pulse(err_pulse), .fs_count(fs_count));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // {rv, rlock[8], rcore[3], dv, dlock[8] | exp: dv, dlock[8], rv, rcore[3], err, fs[2]}
  localparam logic [36:0] VEC [12] = '{
    {1'b1,8'h11,3'd1,1'b0,8'h00, 1'b0,8'h00,1'b0,3'd0,1'b0,2'd0},
    {1'b1,8'h22,3'd2,1'b0,8'h00, 1'b1,8'h11,1'b0,3'd0,1'b0,2'd0},
    {1'b1,8'h11,3'd3,1'b0,8'h00, 1'b1,8'h22,1'b0,3'd0,1'b0,2'd0},
    {1'b1,8'h33,3'd4,1'b0,8'h00, 1'b0,8'h00,1'b0,3'd0,1'b0,2'd0},
    {1'b0,8'h00,3'd0,1'b1,8'h22, 1'b0,8'h00,1'b0,3'd0,1'b0,2'd0},
    {1'b0,8'h00,3'd0,1'b0,8'h00, 1'b1,8'h33,1'b1,3'd2,1'b0,2'd1},
    {1'b0,8'h00,3'd0,1'b1,8'h11, 1'b0,8'h00,1'b0,3'd0,1'b0,2'd1},
    {1'b0,8'h00,3'd0,1'b1,8'h55, 1'b1,8'h11,1'b1,3'd1,1'b0,2'd1},
    {1'b0,8'h00,3'd0,1'b1,8'h33, 1'b0,8'h00,1'b0,3'd0,1'b1,2'd0},
    {1'b0,8'h00,3'd0,1'b1,8'h11, 1'b0,8'h00,1'b1,3'd4,1'b0,2'd0},
    {1'b0,8'h00,3'd0,1'b0,8'h00, 1'b0,8'h00,1'b1,3'd3,1'b0,2'd0},
    {1'b0,8'h00,3'd0,1'b0,8'h00, 1'b0,8'h00,1'b0,3'd0,1'b0,2'd0}
  };

  task automatic do_reset();
    rst_n = 1'b0; req_valid = 1'b0; done_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    do_reset();
    // R9 reset state
    chk("R9 req_ready", 32'(req_ready), 1);
    chk("R9 disp_valid", 32'(disp_valid), 0);
    chk("R9 fs_count", 32'(fs_count), 0);
    chk("R9 resp_valid", 32'(resp_valid), 0);

    // vector walk: R2 dispatch, R3 same-lock hold, R6 response, R7 stray completion, R8 counter
    for (int v = 0; v < 12; v++) begin
      logic [36:0] e;
      e = VEC[v];
      chk($sformatf("R2 step%0d disp_valid", v), 32'(disp_valid), 32'(e[15]));
      if (e[15]) begin
        chk($sformatf("R3 step%0d disp_lock", v), disp_lock, 32'(e[14:7]));
        chk($sformatf("R2 step%0d disp_pc", v), disp_pc, 32'(e[14:7]) + 32'h100);
        chk($sformatf("R2 step%0d disp_sp", v), disp_sp, 32'(e[14:7]) + 32'h200);
      end
      chk($sformatf("R6 step%0d resp_valid", v), 32'(resp_valid), 32'(e[6]));
      if (e[6]) chk($sformatf("R6 step%0d resp_core", v), 32'(resp_core), 32'(e[5:3]));
      chk($sformatf("R7 step%0d err_pulse", v), 32'(err_pulse), 32'(e[2]));
      chk($sformatf("R8 step%0d fs_count", v), 32'(fs_count), 32'(e[1:0]));
      req_valid = e[36]; req_lock = 32'(e[35:28]); req_core = e[27:25];
      done_valid = e[24]; done_lock = 32'(e[23:16]);
      @(negedge clk);
    end

    // directed: fill the table with locks 1..8
    do_reset();
    for (int k = 1; k <= 8; k++) begin
      req_valid = 1'b1; req_lock = 32'(k); req_core = IW'(k);
      @(negedge clk);
      if (k == 2) begin
        chk("R4 second ctx lock", disp_lock, 2);
        chk("R4 second ctx id", 32'(disp_ctx), 1);
      end
    end
    chk("R1 full ready low", 32'(req_ready), 0);
    chk("R4 no third dispatch", 32'(disp_valid), 0);
    chk("R8 saturated", 32'(fs_count), 3);
    // offer lock 9 while full, complete lock 1 at the same edge
    req_lock = 32'd9; req_core = 3'd0; done_valid = 1'b1; done_lock = 32'd1;
    @(negedge clk);
    done_valid = 1'b0;
    chk("R1 ready after free", 32'(req_ready), 1);
    chk("R5 oldest lock3", disp_lock, 3);
    chk("R4 freed ctx0", 32'(disp_ctx), 0);
    chk("R6 resp core1", 32'(resp_core), 1);
    @(negedge clk);
    req_valid = 1'b0; done_valid = 1'b1; done_lock = 32'd2;
    @(negedge clk);
    done_valid = 1'b0;
    chk("R5 older lock4 before lock9", disp_lock, 4);
    chk("R6 resp core2", 32'(resp_core), 2);

    // R9 reset mid-operation
    do_reset();
    chk("R9 ready after reset", 32'(req_ready), 1);
    chk("R9 fs after reset", 32'(fs_count), 0);
    chk("R9 disp after reset", 32'(disp_valid), 0);
    req_valid = 1'b1; req_lock = 32'd4; req_core = 3'd5;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R9 lock freed by reset", 32'(disp_valid), 1);
    chk("R9 lock4 dispatched", disp_lock, 4);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule